// File: doc/BRIEF.md
# Integer Operate Execution Unit

This block is the integer operate stage of a 64-bit load/store RISC core. Each cycle it may take one 32-bit instruction word together with the two 64-bit values read from the register file for the instruction's `ra` and `rb` fields. It decodes the primary opcode and the 7-bit function code, and selects the second operand. That operand is either the register value or an 8-bit literal taken from the instruction and zero-extended. The block then computes a 64-bit result and presents the result, the destination register index and a write-enable one clock later.

The supported operations fall into five groups. The first is plain and scaled add and subtract, in quadword and sign-extended longword forms. The second is signed and unsigned compares that yield 0 or 1. The third is bitwise logic, including forms that complement the second operand. The fourth is left, logical-right and arithmetic-right shifts. The fifth is conditional moves, which test the first operand against zero or test its lowest bit. Register index 31 acts as a hard zero source and a discarded destination. Anything the block does not recognise is flagged as illegal, and nothing is written for it.

Top module: `eu_top`

## Requirements
- R1: Instruction fields are opcode [31:26], ra [25:21], func [11:5] and rc [4:0]. When bit 12 is 1, the second operand is the literal in bits [20:13], zero-extended to 64 bits. When bit 12 is 0, the second operand is the register value selected by rb [20:16].
- R2: Under opcode 0x10, func 0x20 gives a+b and func 0x29 gives a-b over 64 bits. Func 0x00 (add) and 0x09 (subtract) keep the low 32 bits of the same result and sign-extend bit 31 into bits 63:32.
- R3: Under opcode 0x10, the scaled forms compute (a<<2)+b with func 0x22 and 0x02, (a<<2)-b with 0x2B and 0x0B, (a<<3)+b with 0x32 and 0x12, and (a<<3)-b with 0x3B and 0x1B. The first code of each pair is the 64-bit form; the second is the sign-extended 32-bit form.
- R4: Under opcode 0x10, compares write exactly 1 when the relation holds and 0 otherwise: 0x2D equal, 0x4D signed less, 0x6D signed less-or-equal, 0x1D unsigned less, 0x3D unsigned less-or-equal.
- R5: Under opcode 0x11, logic results are a AND b (0x00), a AND NOT b (0x08), a OR b (0x20), a OR NOT b (0x28), a XOR b (0x40) and NOT(a XOR b) (0x48).
- R6: Under opcode 0x12, func 0x39 shifts left, 0x34 shifts right logically and 0x3C shifts right arithmetically. The shift amount is bits [5:0] of the second operand.
- R7: Under opcode 0x11, a conditional move writes b to rc only when its test on a holds: 0x24 a==0, 0x26 a!=0, 0x44 a<0, 0x46 a>=0, 0x64 a<=0, 0x66 a>0, 0x16 bit 0 clear, 0x14 bit 0 set. When the test fails, the write-enable stays low.
- R8: A source index of 31 reads as zero whatever value is presented on the read port, and a destination index of 31 never raises the write-enable.
- R9: An opcode other than 0x10, 0x11 or 0x12, a function code not listed above, or register form (bit 12 = 0) with bits [15:13] nonzero raises the illegal flag and keeps the write-enable low.
- R10: Results appear one clock after an accepted instruction. The output valid follows the input valid with one cycle of delay, the destination output equals rc, and while the output valid is low, write-enable and illegal are low.
- R11: A synchronous reset clears output valid, result, destination, write-enable and illegal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| insn | input | 32 | Operate-format instruction word |
| ra_val | input | 64 | Register file value read for ra |
| rb_val | input | 64 | Register file value read for rb |
| out_valid | output | 1 | Registered outputs hold a completed instruction |
| out_result | output | 64 | Computed result |
| out_dst | output | 5 | Destination register index (rc) |
| out_wen | output | 1 | Write result to out_dst |
| out_illegal | output | 1 | Instruction was not recognised |

## Verification
Every one of the 128 function codes is swept under each of the three opcode groups. Legal codes are run against an 8-by-8 grid of operands, in both register and literal form. The grid holds zero, one, all ones, the most positive and most negative 64-bit values, the 32-bit boundary values 0x7FFFFFFF and 0x80000000, and a mixed pattern. These values separate signed from unsigned compares and show whether bit 31 is sign-extended in longword forms. The literal form shows whether the literal is zero-extended, and the large values show whether the shift amount is masked to six bits. Separate stimuli cover register 31 as a source and as a destination, nonzero must-be-zero bits, opcodes outside the three groups, idle cycles between instructions, and the state just after reset.

// File: rtl/eu_pkg.sv
package eu_pkg;

  localparam logic [5:0] OPC_ARITH = 6'h10;
  localparam logic [5:0] OPC_LOGIC = 6'h11;
  localparam logic [5:0] OPC_SHIFT = 6'h12;

  typedef enum logic [2:0] {
    KD_ARITH, KD_CMP, KD_LOGIC, KD_SHIFT, KD_CMOV, KD_NONE
  } kind_e;

  typedef enum logic [2:0] {
    CM_EQ, CM_LT, CM_LE, CM_ULT, CM_ULE
  } cmp_e;

  typedef enum logic [2:0] {
    LG_AND, LG_ANDN, LG_OR, LG_ORN, LG_XOR, LG_XNOR
  } lgc_e;

  typedef enum logic [1:0] {
    SH_LEFT, SH_RLOG, SH_RARI
  } shf_e;

  typedef enum logic [2:0] {
    MV_EQ, MV_NE, MV_LT, MV_GE, MV_LE, MV_GT, MV_LBC, MV_LBS
  } mv_e;

  typedef struct packed {
    kind_e      kind;
    logic       sub;
    logic [1:0] scale;
    logic       longw;
    cmp_e       cmp;
    lgc_e       lgc;
    shf_e       shf;
    mv_e        mv;
    logic       illegal;
  } dec_t;

endpackage

// File: rtl/eu_decode.sv
module eu_decode
  import eu_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [6:0] func,
  input  logic       lit_sel,
  input  logic [2:0] sbz,
  output dec_t       dec
);

  always_comb begin
    dec       = '0;
    dec.kind  = KD_NONE;
    dec.cmp   = CM_EQ;
    dec.lgc   = LG_AND;
    dec.shf   = SH_LEFT;
    dec.mv    = MV_EQ;
    unique case (opc)
      OPC_ARITH: begin
        unique case (func)
          7'h00: begin dec.kind = KD_ARITH; dec.longw = 1'b1; end
          7'h20: begin dec.kind = KD_ARITH; end
          7'h09: begin dec.kind = KD_ARITH; dec.sub = 1'b1; dec.longw = 1'b1; end
          7'h29: begin dec.kind = KD_ARITH; dec.sub = 1'b1; end
          7'h02: begin dec.kind = KD_ARITH; dec.scale = 2'd2; dec.longw = 1'b1; end
          7'h22: begin dec.kind = KD_ARITH; dec.scale = 2'd2; end
          7'h0B: begin dec.kind = KD_ARITH; dec.scale = 2'd2; dec.sub = 1'b1; dec.longw = 1'b1; end
          7'h2B: begin dec.kind = KD_ARITH; dec.scale = 2'd2; dec.sub = 1'b1; end
          7'h12: begin dec.kind = KD_ARITH; dec.scale = 2'd3; dec.longw = 1'b1; end
          7'h32: begin dec.kind = KD_ARITH; dec.scale = 2'd3; end
          7'h1B: begin dec.kind = KD_ARITH; dec.scale = 2'd3; dec.sub = 1'b1; dec.longw = 1'b1; end
          7'h3B: begin dec.kind = KD_ARITH; dec.scale = 2'd3; dec.sub = 1'b1; end
          7'h2D: begin dec.kind = KD_CMP; dec.cmp = CM_EQ;  end
          7'h4D: begin dec.kind = KD_CMP; dec.cmp = CM_LT;  end
          7'h6D: begin dec.kind = KD_CMP; dec.cmp = CM_LE;  end
          7'h1D: begin dec.kind = KD_CMP; dec.cmp = CM_ULT; end
          7'h3D: begin dec.kind = KD_CMP; dec.cmp = CM_ULE; end
          default: dec.kind = KD_NONE;
        endcase
      end
      OPC_LOGIC: begin
        unique case (func)
          7'h00: begin dec.kind = KD_LOGIC; dec.lgc = LG_AND;  end
          7'h08: begin dec.kind = KD_LOGIC; dec.lgc = LG_ANDN; end
          7'h20: begin dec.kind = KD_LOGIC; dec.lgc = LG_OR;   end
          7'h28: begin dec.kind = KD_LOGIC; dec.lgc = LG_ORN;  end
          7'h40: begin dec.kind = KD_LOGIC; dec.lgc = LG_XOR;  end
          7'h48: begin dec.kind = KD_LOGIC; dec.lgc = LG_XNOR; end
          7'h24: begin dec.kind = KD_CMOV; dec.mv = MV_EQ;  end
          7'h26: begin dec.kind = KD_CMOV; dec.mv = MV_NE;  end
          7'h44: begin dec.kind = KD_CMOV; dec.mv = MV_LT;  end
          7'h46: begin dec.kind = KD_CMOV; dec.mv = MV_GE;  end
          7'h64: begin dec.kind = KD_CMOV; dec.mv = MV_LE;  end
          7'h66: begin dec.kind = KD_CMOV; dec.mv = MV_GT;  end
          7'h16: begin dec.kind = KD_CMOV; dec.mv = MV_LBC; end
          7'h14: begin dec.kind = KD_CMOV; dec.mv = MV_LBS; end
          default: dec.kind = KD_NONE;
        endcase
      end
      OPC_SHIFT: begin
        unique case (func)
          7'h39: begin dec.kind = KD_SHIFT; dec.shf = SH_LEFT; end
          7'h34: begin dec.kind = KD_SHIFT; dec.shf = SH_RLOG; end
          7'h3C: begin dec.kind = KD_SHIFT; dec.shf = SH_RARI; end
          default: dec.kind = KD_NONE;
        endcase
      end
      default: dec.kind = KD_NONE;
    endcase
    dec.illegal = (dec.kind == KD_NONE) || (!lit_sel && (sbz != 3'b000));
  end

endmodule

// File: rtl/eu_arith.sv
module eu_arith
  import eu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        scale,
  input  logic              longw,
  input  cmp_e              cmp,
  output logic [DATA_W-1:0] sum_res,
  output logic [DATA_W-1:0] cmp_res
);

  localparam int EXT_W = DATA_W - LONG_W;

  logic [DATA_W-1:0] a_sc;
  logic [DATA_W-1:0] raw;
  logic              rel;

  // one adder serves plain, scaled, add and subtract forms
  always_comb begin
    a_sc = a << scale;
    raw  = sub ? (a_sc - b) : (a_sc + b);
    if (longw)
      sum_res = {{EXT_W{raw[LONG_W-1]}}, raw[LONG_W-1:0]};
    else
      sum_res = raw;
  end

  always_comb begin
    unique case (cmp)
      CM_EQ:   rel = (a == b);
      CM_LT:   rel = ($signed(a) <  $signed(b));
      CM_LE:   rel = ($signed(a) <= $signed(b));
      CM_ULT:  rel = (a <  b);
      CM_ULE:  rel = (a <= b);
      default: rel = 1'b0;
    endcase
    cmp_res = {{(DATA_W-1){1'b0}}, rel};
  end

endmodule

// File: rtl/eu_logic.sv
module eu_logic
  import eu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lgc_e              lgc,
  input  shf_e              shf,
  input  mv_e               mv,
  output logic [DATA_W-1:0] lgc_res,
  output logic [DATA_W-1:0] shf_res,
  output logic              mv_fire
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] amt;
  logic               a_neg;
  logic               a_zero;

  assign amt    = b[SHAMT_W-1:0];
  assign a_neg  = a[DATA_W-1];
  assign a_zero = (a == '0);

  always_comb begin
    unique case (lgc)
      LG_AND:  lgc_res = a & b;
      LG_ANDN: lgc_res = a & ~b;
      LG_OR:   lgc_res = a | b;
      LG_ORN:  lgc_res = a | ~b;
      LG_XOR:  lgc_res = a ^ b;
      LG_XNOR: lgc_res = ~(a ^ b);
      default: lgc_res = '0;
    endcase
  end

  always_comb begin
    unique case (shf)
      SH_LEFT: shf_res = a << amt;
      SH_RLOG: shf_res = a >> amt;
      SH_RARI: shf_res = $unsigned($signed(a) >>> amt);
      default: shf_res = '0;
    endcase
  end

  always_comb begin
    unique case (mv)
      MV_EQ:   mv_fire = a_zero;
      MV_NE:   mv_fire = !a_zero;
      MV_LT:   mv_fire = a_neg;
      MV_GE:   mv_fire = !a_neg;
      MV_LE:   mv_fire = a_neg || a_zero;
      MV_GT:   mv_fire = !a_neg && !a_zero;
      MV_LBC:  mv_fire = !a[0];
      MV_LBS:  mv_fire = a[0];
      default: mv_fire = 1'b0;
    endcase
  end

endmodule

// File: rtl/eu_top.sv
module eu_top
  import eu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32,
  parameter int LIT_W  = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dst,
  output logic              out_wen,
  output logic              out_illegal
);

  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'((1 << IDX_W) - 1);
  localparam int               EXT_W    = DATA_W - LONG_W;

  logic [IDX_W-1:0]  ra_idx, rb_idx, rc_idx;
  logic [LIT_W-1:0]  lit;
  logic              lit_sel;
  logic [DATA_W-1:0] op_a, op_b;
  dec_t              dec;
  logic [DATA_W-1:0] sum_res, cmp_res, lgc_res, shf_res;
  logic              mv_fire;
  logic [DATA_W-1:0] result;
  logic              fire;

  assign ra_idx  = insn[25:21];
  assign rb_idx  = insn[20:16];
  assign lit     = insn[20:13];
  assign lit_sel = insn[12];
  assign rc_idx  = insn[4:0];

  // index 31 is a hard zero source
  assign op_a = (ra_idx == ZERO_IDX) ? '0 : ra_val;
  assign op_b = lit_sel ? {{(DATA_W-LIT_W){1'b0}}, lit}
              : ((rb_idx == ZERO_IDX) ? '0 : rb_val);

  eu_decode u_dec (
    .opc     (insn[31:26]),
    .func    (insn[11:5]),
    .lit_sel (lit_sel),
    .sbz     (insn[15:13]),
    .dec     (dec)
  );

  eu_arith #(.DATA_W(DATA_W), .LONG_W(LONG_W)) u_arith (
    .a       (op_a),
    .b       (op_b),
    .sub     (dec.sub),
    .scale   (dec.scale),
    .longw   (dec.longw),
    .cmp     (dec.cmp),
    .sum_res (sum_res),
    .cmp_res (cmp_res)
  );

  eu_logic #(.DATA_W(DATA_W)) u_logic (
    .a       (op_a),
    .b       (op_b),
    .lgc     (dec.lgc),
    .shf     (dec.shf),
    .mv      (dec.mv),
    .lgc_res (lgc_res),
    .shf_res (shf_res),
    .mv_fire (mv_fire)
  );

  always_comb begin
    unique case (dec.kind)
      KD_ARITH: result = sum_res;
      KD_CMP:   result = cmp_res;
      KD_LOGIC: result = lgc_res;
      KD_SHIFT: result = shf_res;
      KD_CMOV:  result = op_b;
      default:  result = '0;
    endcase
    fire = (dec.kind == KD_CMOV) ? mv_fire : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dst     <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= in_valid && !dec.illegal && fire && (rc_idx != ZERO_IDX);
      out_illegal <= in_valid && dec.illegal;
      if (in_valid) begin
        out_result <= result;
        out_dst    <= rc_idx;
      end
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_wen); // R9

  AST_ZERO_DST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_dst != ZERO_IDX)); // R8

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_BUBBLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10

  AST_DST_FROM_INSN: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_dst == $past(rc_idx))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_wen && !out_illegal)); // R10

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.kind == KD_CMP) |=> (out_result[DATA_W-1:1] == '0)); // R4

  AST_LONG_SEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.kind == KD_ARITH && dec.longw) |=>
      (out_result[DATA_W-1:LONG_W] == {EXT_W{out_result[LONG_W-1]}})); // R2

  AST_CMOV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.kind == KD_CMOV && !mv_fire) |=> !out_wen); // R7

endmodule

// File: tb/tb_eu_top.sv
module tb_eu_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] ra_val, rb_val;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_dst;
  logic        out_wen;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  logic [63:0] vals [8];

  always #2.5 clk = ~clk;

  eu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .ra_val(ra_val), .rb_val(rb_val), .out_valid(out_valid),
    .out_result(out_result), .out_dst(out_dst), .out_wen(out_wen),
    .out_illegal(out_illegal)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] ra,
      input logic [4:0] rb, input logic [6:0] f, input logic [4:0] rc,
      input logic uselit, input logic [7:0] lit);
    if (uselit) return {opc, ra, lit, 1'b1, f, rc};
    return {opc, ra, rb, 3'b000, 1'b0, f, rc};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    logic [6:0] f;
    f = ins[11:5];
    case (ins[31:26])
      6'h10: begin
        if (f == 7'h2D || f == 7'h4D || f == 7'h6D || f == 7'h1D || f == 7'h3D) return "R4";
        if (f == 7'h00 || f == 7'h20 || f == 7'h09 || f == 7'h29) return "R2";
        return "R3";
      end
      6'h11: begin
        if (f == 7'h00 || f == 7'h08 || f == 7'h20 || f == 7'h28 || f == 7'h40 || f == 7'h48) return "R5";
        return "R7";
      end
      6'h12: return "R6";
      default: return "R9";
    endcase
  endfunction

  // reference computed from the requirements
  task automatic model(input logic [31:0] ins, input logic [63:0] rav, input logic [63:0] rbv,
      output logic [63:0] r, output logic w, output logic ill);
    logic [63:0] a, b;
    logic fire;
    logic [6:0] f;
    f = ins[11:5];
    a = (ins[25:21] == 5'd31) ? 64'd0 : rav;
    b = ins[12] ? {56'd0, ins[20:13]} : ((ins[20:16] == 5'd31) ? 64'd0 : rbv);
    r = 64'd0; fire = 1'b1; ill = 1'b0;
    case (ins[31:26])
      6'h10: case (f)
        7'h00: r = sx32(a + b);
        7'h20: r = a + b;
        7'h09: r = sx32(a - b);
        7'h29: r = a - b;
        7'h02: r = sx32((a << 2) + b);
        7'h22: r = (a << 2) + b;
        7'h0B: r = sx32((a << 2) - b);
        7'h2B: r = (a << 2) - b;
        7'h12: r = sx32((a << 3) + b);
        7'h32: r = (a << 3) + b;
        7'h1B: r = sx32((a << 3) - b);
        7'h3B: r = (a << 3) - b;
        7'h2D: r = {63'd0, a == b};
        7'h4D: r = {63'd0, $signed(a) < $signed(b)};
        7'h6D: r = {63'd0, $signed(a) <= $signed(b)};
        7'h1D: r = {63'd0, a < b};
        7'h3D: r = {63'd0, a <= b};
        default: ill = 1'b1;
      endcase
      6'h11: case (f)
        7'h00: r = a & b;
        7'h08: r = a & ~b;
        7'h20: r = a | b;
        7'h28: r = a | ~b;
        7'h40: r = a ^ b;
        7'h48: r = ~(a ^ b);
        7'h24: begin r = b; fire = (a == 0); end
        7'h26: begin r = b; fire = (a != 0); end
        7'h44: begin r = b; fire = a[63]; end
        7'h46: begin r = b; fire = !a[63]; end
        7'h64: begin r = b; fire = a[63] || (a == 0); end
        7'h66: begin r = b; fire = !a[63] && (a != 0); end
        7'h16: begin r = b; fire = !a[0]; end
        7'h14: begin r = b; fire = a[0]; end
        default: ill = 1'b1;
      endcase
      6'h12: case (f)
        7'h39: r = a << b[5:0];
        7'h34: r = a >> b[5:0];
        7'h3C: r = $unsigned($signed(a) >>> b[5:0]);
        default: ill = 1'b1;
      endcase
      default: ill = 1'b1;
    endcase
    if (!ins[12] && ins[15:13] != 3'b000) ill = 1'b1;
    w = !ill && fire && (ins[4:0] != 5'd31);
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b, input string req);
    logic [63:0] er;
    logic ew, eil;
    model(ins, a, b, er, ew, eil);
    in_valid = 1'b1; insn = ins; ra_val = a; rb_val = b;
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid", {63'd0, out_valid}, 64'd1);
    chk(out_illegal == eil, req, {63'd0, out_illegal}, {63'd0, eil});
    chk(out_wen == ew, req, {63'd0, out_wen}, {63'd0, ew});
    if (ew) begin
      chk(out_result == er, req, out_result, er);
      chk(out_dst == ins[4:0], "R10 dst", {59'd0, out_dst}, {59'd0, ins[4:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] opcs [3];
    logic [63:0] er;
    logic ew, eil;
    opcs[0] = 6'h10; opcs[1] = 6'h11; opcs[2] = 6'h12;
    vals[0] = 64'd0;
    vals[1] = 64'd1;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[5] = 64'h0000_0000_7FFF_FFFF;
    vals[6] = 64'h0000_0000_8000_0000;
    vals[7] = 64'h1234_5678_9ABC_DEF0;
    rst = 1'b1; in_valid = 1'b0; insn = '0; ra_val = '0; rb_val = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 0 && out_wen == 0 && out_illegal == 0, "R11 flags",
        {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    chk(out_result == 0 && out_dst == 0, "R11 data", out_result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R10 idle", {63'd0, out_valid}, 64'd0);

    // sweep every function code of each group
    for (int o = 0; o < 3; o++) begin
      for (int f = 0; f < 128; f++) begin
        logic [31:0] probe;
        probe = mk(opcs[o], 5'd1, 5'd2, 7'(f), 5'd3, 1'b0, 8'd0);
        model(probe, 64'd0, 64'd0, er, ew, eil);
        if (eil) begin
          run(probe, vals[7], vals[2], "R9");
        end else begin
          for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
              logic [31:0] ri, li;
              ri = mk(opcs[o], 5'd1, 5'd2, 7'(f), 5'd3, 1'b0, 8'd0);
              li = mk(opcs[o], 5'd1, 5'd2, 7'(f), 5'd3, 1'b1, vals[j][7:0] ^ 8'(i));
              run(ri, vals[i], vals[j], tag_of(ri));
              run(li, vals[i], vals[j], tag_of(li));
            end
          end
        end
      end
    end

    // R1: literal zero-extended and register read port ignored
    run(mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd4, 1'b1, 8'hFF), 64'd5, 64'hDEAD_BEEF, "R1");
    chk(out_result == 64'h104, "R1 literal", out_result, 64'h104);
    // R8: zero-register sources
    run(mk(6'h10, 5'd31, 5'd2, 7'h20, 5'd4, 1'b0, 8'd0), 64'hFFFF, 64'd7, "R8");
    chk(out_result == 64'd7, "R8 ra31", out_result, 64'd7);
    run(mk(6'h11, 5'd1, 5'd31, 7'h20, 5'd4, 1'b0, 8'd0), 64'd9, 64'hFFFF, "R8");
    chk(out_result == 64'd9, "R8 rb31", out_result, 64'd9);
    // R8: write to index 31 dropped
    run(mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd31, 1'b0, 8'd0), 64'd1, 64'd1, "R8");
    chk(out_wen == 0, "R8 rc31", {63'd0, out_wen}, 64'd0);
    // R9: nonzero must-be-zero bits, foreign opcodes
    run(mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd3, 1'b0, 8'd0) | 32'h0000_2000, 64'd1, 64'd1, "R9");
    chk(out_illegal == 1, "R9 sbz", {63'd0, out_illegal}, 64'd1);
    run(mk(6'h13, 5'd1, 5'd2, 7'h00, 5'd3, 1'b0, 8'd0), 64'd1, 64'd1, "R9");
    run(mk(6'h00, 5'd1, 5'd2, 7'h20, 5'd3, 1'b1, 8'd1), 64'd1, 64'd1, "R9");
    // R7: move that does not fire
    run(mk(6'h11, 5'd1, 5'd2, 7'h24, 5'd3, 1'b0, 8'd0), 64'd1, 64'd5, "R7");
    chk(out_wen == 0, "R7 no fire", {63'd0, out_wen}, 64'd0);
    // R10: bubble after activity
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && out_wen == 0 && out_illegal == 0, "R10 bubble",
        {61'd0, out_valid, out_wen, out_illegal}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule